// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This unit owns the program counter of a small multi-cycle processor. Each cycle it takes one of three requests: an interrupt load, the execute step of a decoded flow-control operation, or a fetch advance. From that request it works out the next program counter. Flow-control operations cover an unconditional jump, six conditional branches that test only the sign flag S and the zero flag Z, subroutine call, return, and return-from-interrupt.

Return addresses live in a private last-in first-out stack inside the unit. A call and an interrupt load both push the current program counter. A return pops it back. A push into a full stack, or a pop from an empty one, is refused. The program counter then keeps its value and a sticky fault flag is raised. A successful return-from-interrupt also produces a one-cycle pulse that the surrounding logic uses to re-enable interrupts.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0, the stack becomes empty, and both `stack_fault` and `gie_set` become 0.
- R2: With `fetch_adv` high and neither `exec_valid` nor `irq_load` high, the program counter increases by one at the next edge. It wraps from all ones to 0.
- R3: An execute of the jump code (`exec_op` = 1) loads `target` into the program counter at the next edge.
- R4: Branch-if-equal (code 2) loads `target` when `flag_z` is 1. Branch-if-not-equal (code 3) loads it when `flag_z` is 0.
- R5: Branch-if-greater-or-equal (code 4) loads `target` when `flag_s` is 0. Branch-if-less-than (code 7) loads it when `flag_s` is 1.
- R6: Branch-if-greater-than (code 5) loads `target` only when `flag_s` and `flag_z` are both 0. Branch-if-less-or-equal (code 6) loads it when either flag is 1.
- R7: An execute whose branch condition is false, or whose code is 0 or any code above 10, leaves the program counter unchanged. `fetch_adv` has no effect in any cycle where `exec_valid` is high.
- R8: A call (code 8) pushes the current program counter and loads `target`. A return (code 9) pops the most recent entry into the program counter. Nested calls return in last-in first-out order, and a return produces no `gie_set` pulse.
- R9: A return-from-interrupt (code 10) pops the stack like a return. It also drives `gie_set` high for exactly the one cycle after the edge that performs the pop.
- R10: The stack holds STACK_DEPTH entries (16 by default). A push request while the stack is full is refused: the program counter keeps its value, the stack contents are kept, and `stack_fault` becomes 1.
- R11: A return of either kind with an empty stack keeps the program counter, gives no `gie_set` pulse, and sets `stack_fault`. Once set, `stack_fault` stays at 1 until reset.
- R12: `irq_load` has priority over `exec_valid` and `fetch_adv` in the same cycle. It pushes the current program counter and loads `irq_vector`, and a later return brings back the pushed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_adv | input | 1 | Advance the program counter after a fetch |
| exec_valid | input | 1 | Apply the flow operation in `exec_op` this cycle |
| exec_op | input | 4 | Flow operation code (0 none, 1 jump, 2..7 branches, 8 call, 9 return, 10 return-from-interrupt) |
| target | input | PC_W | Jump, branch or call destination |
| flag_s | input | 1 | Sign flag from the status register |
| flag_z | input | 1 | Zero flag from the status register |
| irq_load | input | 1 | Interrupt controller forces a vector and a push |
| irq_vector | input | PC_W | Interrupt vector address |
| pc | output | PC_W | Current program counter |
| gie_set | output | 1 | One-cycle pulse to set the global interrupt enable |
| stack_fault | output | 1 | Sticky flag for stack overflow or underflow |

## Verification
The stack pointer and the stored entries are never visible at the ports. A corrupted entry or an off-by-one pointer shows up only when something is popped: the program counter takes a wrong value one edge after the return. An early overflow or underflow shows up instead as a `stack_fault` rise and a frozen program counter. The bench fills the stack to its limit, pushes once more, then drains it completely and pops once past empty. This checks every entry and both pointer boundaries. A flag-decode error appears as a wrong program counter one edge after the branch, so every branch code is driven with all four S/Z combinations.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_JMP  = 4'd1,
        OP_BEQ  = 4'd2,
        OP_BNE  = 4'd3,
        OP_BGE  = 4'd4,
        OP_BGT  = 4'd5,
        OP_BLE  = 4'd6,
        OP_BLT  = 4'd7,
        OP_CALL = 4'd8,
        OP_RET  = 4'd9,
        OP_RETI = 4'd10
    } flow_op_e;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_TARGET,
        SEL_VECTOR,
        SEL_STACK
    } pc_sel_e;

    typedef struct packed {
        pc_sel_e sel;
        logic    push;
        logic    pop;
        logic    ie_pulse;
        logic    fault;
    } flow_ctl_t;

    // Condition test for the six conditional forms; other codes return 0.
    function automatic logic branch_taken(flow_op_e op, logic s, logic z);
        case (op)
            OP_BEQ:  return z;
            OP_BNE:  return !z;
            OP_BGE:  return !s;
            OP_BLT:  return s;
            OP_BGT:  return !s && !z;
            OP_BLE:  return s || z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_branch(flow_op_e op);
        return (op >= OP_BEQ) && (op <= OP_BLT);
    endfunction

endpackage

// File: rtl/pcseq_flow_ctl.sv
module pcseq_flow_ctl
    import pcseq_pkg::*;
(
    input  logic      fetch_adv,
    input  logic      exec_valid,
    input  flow_op_e  op,
    input  logic      flag_s,
    input  logic      flag_z,
    input  logic      irq_load,
    input  logic      stk_full,
    input  logic      stk_empty,
    output flow_ctl_t ctl
);

    always_comb begin
        ctl          = '0;
        ctl.sel      = SEL_HOLD;
        if (irq_load) begin
            if (stk_full) begin
                ctl.fault = 1'b1;
            end else begin
                ctl.push = 1'b1;
                ctl.sel  = SEL_VECTOR;
            end
        end else if (exec_valid) begin
            if (op == OP_JMP) begin
                ctl.sel = SEL_TARGET;
            end else if (is_branch(op)) begin
                if (branch_taken(op, flag_s, flag_z)) begin
                    ctl.sel = SEL_TARGET;
                end
            end else if (op == OP_CALL) begin
                if (stk_full) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.push = 1'b1;
                    ctl.sel  = SEL_TARGET;
                end
            end else if (op == OP_RET || op == OP_RETI) begin
                if (stk_empty) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.pop      = 1'b1;
                    ctl.sel      = SEL_STACK;
                    ctl.ie_pulse = (op == OP_RETI);
                end
            end
        end else if (fetch_adv) begin
            ctl.sel = SEL_INC;
        end
    end

endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = IDX_W'(count);
    assign rd_idx = IDX_W'(count - CNT_ONE);
    assign full   = (count == CNT_MAX);
    assign empty  = (count == '0);
    assign top    = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CNT_ONE;
        end else if (pop && !empty) begin
            count <= count - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem[wr_idx] <= din;
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_adv,
    input  logic            exec_valid,
    input  logic [3:0]      exec_op,
    input  logic [PC_W-1:0] target,
    input  logic            flag_s,
    input  logic            flag_z,
    input  logic            irq_load,
    input  logic [PC_W-1:0] irq_vector,
    output logic [PC_W-1:0] pc,
    output logic            gie_set,
    output logic            stack_fault
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    flow_ctl_t       ctl;
    logic            stk_full;
    logic            stk_empty;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] pc_next;

    pcseq_flow_ctl u_ctl (
        .fetch_adv  (fetch_adv),
        .exec_valid (exec_valid),
        .op         (flow_op_e'(exec_op)),
        .flag_s     (flag_s),
        .flag_z     (flag_z),
        .irq_load   (irq_load),
        .stk_full   (stk_full),
        .stk_empty  (stk_empty),
        .ctl        (ctl)
    );

    pcseq_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (ctl.push),
        .pop   (ctl.pop),
        .din   (pc),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_comb begin
        case (ctl.sel)
            SEL_INC:    pc_next = pc + PC_ONE;
            SEL_TARGET: pc_next = target;
            SEL_VECTOR: pc_next = irq_vector;
            SEL_STACK:  pc_next = stk_top;
            default:    pc_next = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= '0;
            gie_set     <= 1'b0;
            stack_fault <= 1'b0;
        end else begin
            pc      <= pc_next;
            gie_set <= ctl.ie_pulse;
            if (ctl.fault) begin
                stack_fault <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk
    import pcseq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            fetch_adv,
    input logic            exec_valid,
    input logic [3:0]      exec_op,
    input logic [PC_W-1:0] target,
    input logic            flag_s,
    input logic            flag_z,
    input logic            irq_load,
    input logic [PC_W-1:0] irq_vector,
    input logic [PC_W-1:0] pc,
    input logic            gie_set,
    input logic            stack_fault,
    input logic            stk_full,
    input logic            stk_empty
);

    logic exe;
    assign exe = exec_valid && !irq_load;

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_adv && !exec_valid && !irq_load) |=> (pc == PC_W'($past(pc) + 1)));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (exe && exec_op == 4'(OP_JMP)) |=> (pc == $past(target)));

    // R4
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (exe && exec_op == 4'(OP_BEQ) && flag_z) |=> (pc == $past(target)));

    // R6
    bgt_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (exe && exec_op == 4'(OP_BGT) && (flag_s || flag_z)) |=> $stable(pc));

    // R10
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_load || (exe && exec_op == 4'(OP_CALL))) && stk_full)
        |=> (stack_fault && $stable(pc)));

    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stack_fault |=> stack_fault);

    // R9
    reti_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (exe && exec_op == 4'(OP_RETI) && !stk_empty) |=> gie_set);

    // R9
    gie_source_chk: assert property (@(posedge clk) disable iff (rst)
        gie_set |-> $past(exe && exec_op == 4'(OP_RETI)));

    // R12
    irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_load && !stk_full) |=> (pc == $past(irq_vector)));

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_full && stk_empty));

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_adv   (fetch_adv),
    .exec_valid  (exec_valid),
    .exec_op     (exec_op),
    .target      (target),
    .flag_s      (flag_s),
    .flag_z      (flag_z),
    .irq_load    (irq_load),
    .irq_vector  (irq_vector),
    .pc          (pc),
    .gie_set     (gie_set),
    .stack_fault (stack_fault),
    .stk_full    (stk_full),
    .stk_empty   (stk_empty)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 16;
    localparam int DEPTH      = 16;

    // Branch table: {code[3:0], S, Z, taken}
    localparam logic [6:0] BR_TBL [24] = '{
        {4'd2, 1'b0, 1'b0, 1'b0}, {4'd2, 1'b0, 1'b1, 1'b1},
        {4'd2, 1'b1, 1'b0, 1'b0}, {4'd2, 1'b1, 1'b1, 1'b1},
        {4'd3, 1'b0, 1'b0, 1'b1}, {4'd3, 1'b0, 1'b1, 1'b0},
        {4'd3, 1'b1, 1'b0, 1'b1}, {4'd3, 1'b1, 1'b1, 1'b0},
        {4'd4, 1'b0, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b1, 1'b1},
        {4'd4, 1'b1, 1'b0, 1'b0}, {4'd4, 1'b1, 1'b1, 1'b0},
        {4'd5, 1'b0, 1'b0, 1'b1}, {4'd5, 1'b0, 1'b1, 1'b0},
        {4'd5, 1'b1, 1'b0, 1'b0}, {4'd5, 1'b1, 1'b1, 1'b0},
        {4'd6, 1'b0, 1'b0, 1'b0}, {4'd6, 1'b0, 1'b1, 1'b1},
        {4'd6, 1'b1, 1'b0, 1'b1}, {4'd6, 1'b1, 1'b1, 1'b1},
        {4'd7, 1'b0, 1'b0, 1'b0}, {4'd7, 1'b0, 1'b1, 1'b0},
        {4'd7, 1'b1, 1'b0, 1'b1}, {4'd7, 1'b1, 1'b1, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fetch_adv = 1'b0;
    logic            exec_valid = 1'b0;
    logic [3:0]      exec_op = '0;
    logic [PC_W-1:0] target = '0;
    logic            flag_s = 1'b0;
    logic            flag_z = 1'b0;
    logic            irq_load = 1'b0;
    logic [PC_W-1:0] irq_vector = '0;
    logic [PC_W-1:0] pc;
    logic            gie_set;
    logic            stack_fault;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_sequencer #(.PC_W(PC_W), .STACK_DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_adv   (fetch_adv),
        .exec_valid  (exec_valid),
        .exec_op     (exec_op),
        .target      (target),
        .flag_s      (flag_s),
        .flag_z      (flag_z),
        .irq_load    (irq_load),
        .irq_vector  (irq_vector),
        .pc          (pc),
        .gie_set     (gie_set),
        .stack_fault (stack_fault)
    );

    task automatic chk(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic f, input logic ev, input logic [3:0] op,
                        input logic [PC_W-1:0] tg, input logic s, input logic z,
                        input logic irq, input logic [PC_W-1:0] vec);
        fetch_adv  = f;
        exec_valid = ev;
        exec_op    = op;
        target     = tg;
        flag_s     = s;
        flag_z     = z;
        irq_load   = irq;
        irq_vector = vec;
        @(negedge clk);
        fetch_adv  = 1'b0;
        exec_valid = 1'b0;
        exec_op    = '0;
        irq_load   = 1'b0;
    endtask

    task automatic exec(input logic [3:0] op, input logic [PC_W-1:0] tg);
        step(1'b0, 1'b1, op, tg, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string br_tag(input logic [3:0] op, input logic taken);
        string t;
        if (op == 4'd2 || op == 4'd3)      t = "R4";
        else if (op == 4'd4 || op == 4'd7) t = "R5";
        else                               t = "R6";
        if (!taken) t = {t, "/R7"};
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 pc", pc, 16'h0000);
        chk("R1 fault", 16'(stack_fault), 16'h0);
        chk("R1 gie", 16'(gie_set), 16'h0);

        // Branch table
        for (int i = 0; i < 24; i++) begin
            logic [3:0] op;
            logic       s, z, tk;
            {op, s, z, tk} = BR_TBL[i];
            exec(4'd1, 16'h0200);
            step(1'b0, 1'b1, op, 16'h0300 + 16'(i), s, z, 1'b0, '0);
            chk(br_tag(op, tk), pc, tk ? 16'h0300 + 16'(i) : 16'h0200);
        end

        // R3 jump, R2 fetch advance and wrap
        exec(4'd1, 16'h1234);
        chk("R3 jump", pc, 16'h1234);
        step(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 incr", pc, 16'h1235);
        step(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 incr2", pc, 16'h1236);
        exec(4'd1, 16'hFFFF);
        step(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R2 wrap", pc, 16'h0000);

        // R7 no-flow codes ignore fetch_adv and target
        exec(4'd1, 16'h0500);
        step(1'b1, 1'b1, 4'd0, 16'h0777, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 code0", pc, 16'h0500);
        step(1'b1, 1'b1, 4'd15, 16'h0777, 1'b1, 1'b1, 1'b0, '0);
        chk("R7 code15", pc, 16'h0500);
        step(1'b1, 1'b1, 4'd2, 16'h0777, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 untaken+fetch", pc, 16'h0500);

        // R8 nested call / return
        exec(4'd1, 16'h0040);
        exec(4'd8, 16'h0080);
        chk("R8 call", pc, 16'h0080);
        step(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        exec(4'd8, 16'h0090);
        chk("R8 call2", pc, 16'h0090);
        exec(4'd9, 16'h0EEE);
        chk("R8 ret inner", pc, 16'h0081);
        chk("R8 ret no gie", 16'(gie_set), 16'h0);
        exec(4'd9, 16'h0EEE);
        chk("R8 ret outer", pc, 16'h0040);

        // R9 return-from-interrupt pulse
        exec(4'd8, 16'h0055);
        exec(4'd10, '0);
        chk("R9 reti pc", pc, 16'h0040);
        chk("R9 gie high", 16'(gie_set), 16'h1);
        step(1'b0, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 gie one cycle", 16'(gie_set), 16'h0);

        // R12 interrupt load wins over jump and fetch
        exec(4'd1, 16'h0123);
        step(1'b1, 1'b1, 4'd1, 16'h0777, 1'b0, 1'b0, 1'b1, 16'h0010);
        chk("R12 vector", pc, 16'h0010);
        exec(4'd10, '0);
        chk("R12 return", pc, 16'h0123);
        chk("R12 gie", 16'(gie_set), 16'h1);
        chk("R12 no fault", 16'(stack_fault), 16'h0);

        // R10 overflow, then full drain, R11 underflow
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            exec(4'd8, 16'h0100 + 16'(i));
        end
        chk("R10 full pc", pc, 16'h010F);
        chk("R10 no fault yet", 16'(stack_fault), 16'h0);
        exec(4'd8, 16'h0999);
        chk("R10 overflow pc", pc, 16'h010F);
        chk("R10 overflow fault", 16'(stack_fault), 16'h1);
        step(1'b0, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b1, 16'h0AAA);
        chk("R10 irq overflow pc", pc, 16'h010F);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            exec(4'd9, '0);
            chk("R10 drain", pc, (i == 0) ? 16'h0000 : 16'h0100 + 16'(i - 1));
        end
        exec(4'd10, '0);
        chk("R11 underflow pc", pc, 16'h0000);
        chk("R11 underflow gie", 16'(gie_set), 16'h0);
        chk("R11 fault sticky", 16'(stack_fault), 16'h1);
        step(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0);
        chk("R11 sticky later", 16'(stack_fault), 16'h1);

        // R11 underflow from a clean state; R1 reset clears fault
        do_reset();
        chk("R1 fault cleared", 16'(stack_fault), 16'h0);
        exec(4'd9, 16'h0321);
        chk("R11 empty ret pc", pc, 16'h0000);
        chk("R11 empty ret fault", 16'(stack_fault), 16'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule